// File: doc/BRIEF.md
# Prescaled Four-Channel Timer Unit

The block is a general-purpose timer peripheral. A single prescaler divides an external tick enable into a slower pulse, and that pulse drives a bank of down-counting channels. Each channel has a counter, a reload value and a control word. When a channel counts below zero it underflows. It then either reloads and keeps running, or stops. It can also latch a pending flag that drives its own interrupt line. A channel can instead be chained, so that it counts the underflows of the channel before it rather than prescaler pulses.

Software reaches every register through a word-wide peripheral bus with byte enables, and only full-word accesses take effect. The last channel leaves reset already armed as a watchdog. Its counter holds a large initial value and it raises its interrupt unless software disables it or feeds it first.

Top module: `multi_timer`

## Requirements
- R1: After reset the prescaler counter and reload read 0, channels 0 to 2 read 0 in every register, channel 3 control reads 0x09 with counter and reload both 0xFFFF, and all irq lines are low.
- R2: On each cycle with tick high, the prescaler counter is reloaded from the prescaler reload register and emits one pulse if it is 1 or 0; otherwise it decrements by one. A reload value P of at least 1 therefore gives one pulse every P ticks, and P=0 gives a pulse on every tick.
- R3: A channel with control bit 0 (enable) set and bit 5 (chain) clear decrements once per prescaler pulse; a pulse that finds its counter at 0 is an underflow.
- R4: On underflow, a channel with control bit 1 (restart) set copies its reload value into the counter; with bit 1 clear it clears its enable bit and its counter stays 0.
- R5: On underflow, a channel with control bit 3 (interrupt enable) set sets its pending bit (control bit 4). irq[n] is high exactly while channel n's pending bit is set, and no pending bit is set when bit 3 is clear.
- R6: Writing a control word with bit 2 set copies the channel's reload value into its counter; bit 2 always reads back 0.
- R7: Writing a control word with bit 4 clear clears the pending bit; writing it with bit 4 set leaves the pending bit unchanged.
- R8: Control bits 0, 1, 3 and 5 take the written value (writable mask 0x2B); bit 6 and bits 31:7 always read 0.
- R9: A channel with chain bit 5 set ignores prescaler pulses and decrements once for each underflow of the channel with the next lower index.
- R10: An access whose byte enables are not all set writes nothing and reads 0.
- R11: Register map (byte address): 0x00 prescaler counter, 0x04 prescaler reload; channel n at 0x10+0x10*n with counter at +0, reload at +4 and control at +8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Tick enable fed to the prescaler |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_be | input | 4 | Byte enables; only 4'hF takes effect |
| bus_addr | input | ADDR_W (7) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the selected register |
| irq | output | N_TMR (4) | One interrupt line per channel, high while its pending bit is set |

## Verification
The counting path is run under three stimulus patterns. Under the reset prescaler setting of one pulse per tick, the armed watchdog is run all the way to underflow. This separates the stop behaviour from the restart behaviour. A prescaler reload of 3 is then used with restart set, first with interrupt enable set and then with it clear. Reading the prescaler counter mid-period pins its phase, and the two runs show that reload and pending-flag setting are independent. Chaining a second channel onto the first shows that a chained counter holds its value across prescaler pulses and moves only when the first channel underflows. Finally, register writes that carry stray bits, partial byte enables and load triggers check which control bits are stored and which are discarded.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
    localparam int unsigned B_EN = 0;
    localparam int unsigned B_RS = 1;
    localparam int unsigned B_LD = 2;
    localparam int unsigned B_IE = 3;
    localparam int unsigned B_IP = 4;
    localparam int unsigned B_CH = 5;

    typedef struct packed {
        logic en;
        logic rs;
        logic ie;
        logic ip;
        logic ch;
    } ctl_t;
endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
    parameter int unsigned PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             cnt_we,
    input  logic             rel_we,
    input  logic [PRE_W-1:0] wdata,
    output logic [PRE_W-1:0] cnt_o,
    output logic [PRE_W-1:0] rel_o,
    output logic             pulse_o
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
        logic [PRE_W-1:0] rel;
    } pre_t;

    pre_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        pulse_o = 1'b0;
        if (tick) begin
            if (s_q.cnt <= PRE_W'(1)) begin
                s_d.cnt = s_q.rel;
                pulse_o = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - PRE_W'(1);
            end
        end
        if (cnt_we) s_d.cnt = wdata;
        if (rel_we) s_d.rel = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;
    assign rel_o = s_q.rel;
endmodule

// File: rtl/mt_channel.sv
module mt_channel
    import mtimer_pkg::*;
#(
    parameter int unsigned      CNT_W     = 32,
    parameter logic [CNT_W-1:0] RST_VAL   = '0,
    parameter bit               RST_ARMED = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pulse_i,
    input  logic             chain_i,
    input  logic             cnt_we,
    input  logic             rel_we,
    input  logic             ctl_we,
    input  logic [31:0]      wdata,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] rel_o,
    output logic [31:0]      ctl_o,
    output logic             irq_o,
    output logic             uflow_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rel;
        ctl_t             ctl;
    } chan_t;

    chan_t s_d, s_q;
    logic  step;
    logic  ip_set;

    always_comb begin
        s_d     = s_q;
        uflow_o = 1'b0;
        ip_set  = 1'b0;
        step    = s_q.ctl.en && (s_q.ctl.ch ? chain_i : pulse_i);
        if (step) begin
            if (s_q.cnt == '0) begin
                uflow_o = 1'b1;
                ip_set  = s_q.ctl.ie;
                if (s_q.ctl.rs) s_d.cnt    = s_q.rel;
                else            s_d.ctl.en = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end
        end
        if (cnt_we) s_d.cnt = wdata[CNT_W-1:0];
        if (rel_we) s_d.rel = wdata[CNT_W-1:0];
        if (ctl_we) begin
            s_d.ctl.en = wdata[B_EN];
            s_d.ctl.rs = wdata[B_RS];
            s_d.ctl.ie = wdata[B_IE];
            s_d.ctl.ch = wdata[B_CH];
            if (!wdata[B_IP]) s_d.ctl.ip = 1'b0;
            if (wdata[B_LD])  s_d.cnt    = s_q.rel;
        end
        if (ip_set) s_d.ctl.ip = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q        <= '0;
            s_q.cnt    <= RST_VAL;
            s_q.rel    <= RST_VAL;
            s_q.ctl.en <= RST_ARMED;
            s_q.ctl.ie <= RST_ARMED;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        ctl_o       = '0;
        ctl_o[B_EN] = s_q.ctl.en;
        ctl_o[B_RS] = s_q.ctl.rs;
        ctl_o[B_IE] = s_q.ctl.ie;
        ctl_o[B_IP] = s_q.ctl.ip;
        ctl_o[B_CH] = s_q.ctl.ch;
    end

    assign cnt_o = s_q.cnt;
    assign rel_o = s_q.rel;
    assign irq_o = s_q.ctl.ip;
endmodule

// File: rtl/multi_timer.sv
module multi_timer #(
    parameter int unsigned N_TMR     = 4,
    parameter int unsigned CNT_W     = 32,
    parameter int unsigned PRE_W     = 16,
    parameter int unsigned WDOG_INIT = 32'h0000_FFFF,
    parameter int unsigned ADDR_W    = $clog2((N_TMR + 1) * 16)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [3:0]        bus_be,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [N_TMR-1:0]  irq
);
    localparam int unsigned BLK_W = ADDR_W - 4;

    logic             full;
    logic             wr_ok;
    logic [BLK_W-1:0] blk;
    logic [1:0]       off;
    logic [PRE_W-1:0] pre_cnt, pre_rel;
    logic             pulse;
    logic [31:0]      rd_cnt [N_TMR];
    logic [31:0]      rd_rel [N_TMR];
    logic [31:0]      rd_ctl [N_TMR];

    assign full  = (bus_be == 4'hF);
    assign wr_ok = bus_sel && bus_wr && full;
    assign blk   = bus_addr[ADDR_W-1:4];
    assign off   = bus_addr[3:2];

    mt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .cnt_we (wr_ok && blk == '0 && off == 2'd0),
        .rel_we (wr_ok && blk == '0 && off == 2'd1),
        .wdata  (bus_wdata[PRE_W-1:0]),
        .cnt_o  (pre_cnt),
        .rel_o  (pre_rel),
        .pulse_o(pulse)
    );

    for (genvar i = 0; i < N_TMR; i++) begin : g_ch
        logic             uf;
        logic             chain;
        logic             hit;
        logic [CNT_W-1:0] c_cnt, c_rel;

        if (i == 0) begin : g_head
            assign chain = 1'b0;
        end else begin : g_link
            assign chain = g_ch[i-1].uf;
        end

        assign hit = wr_ok && (blk == BLK_W'(i + 1));

        mt_channel #(
            .CNT_W    (CNT_W),
            .RST_VAL  ((i == N_TMR - 1) ? CNT_W'(WDOG_INIT) : CNT_W'(0)),
            .RST_ARMED(i == N_TMR - 1)
        ) u_ch (
            .clk    (clk),
            .rst    (rst),
            .pulse_i(pulse),
            .chain_i(chain),
            .cnt_we (hit && off == 2'd0),
            .rel_we (hit && off == 2'd1),
            .ctl_we (hit && off == 2'd2),
            .wdata  (bus_wdata),
            .cnt_o  (c_cnt),
            .rel_o  (c_rel),
            .ctl_o  (rd_ctl[i]),
            .irq_o  (irq[i]),
            .uflow_o(uf)
        );

        assign rd_cnt[i] = 32'(c_cnt);
        assign rd_rel[i] = 32'(c_rel);
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && full) begin
            if (blk == '0) begin
                case (off)
                    2'd0:    bus_rdata = 32'(pre_cnt);
                    2'd1:    bus_rdata = 32'(pre_rel);
                    default: bus_rdata = '0;
                endcase
            end
            for (int i = 0; i < N_TMR; i++) begin
                if (blk == BLK_W'(i + 1)) begin
                    case (off)
                        2'd0:    bus_rdata = rd_cnt[i];
                        2'd1:    bus_rdata = rd_rel[i];
                        2'd2:    bus_rdata = rd_ctl[i];
                        default: bus_rdata = '0;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/multi_timer_chk.sv
module multi_timer_chk #(
    parameter int unsigned N_TMR  = 4,
    parameter int unsigned ADDR_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [3:0]        bus_be,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [N_TMR-1:0]  irq
);
    // R1: lines are low the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk) rst |=> irq == '0);

    // R10: partial byte enables read zero
    p_partial_read_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_be != 4'hF) |-> bus_rdata == '0);

    for (genvar n = 0; n < N_TMR; n++) begin : g_n
        logic ctl_acc;
        assign ctl_acc = bus_sel && bus_be == 4'hF
                      && bus_addr == ADDR_W'((n + 1) * 16 + 8);

        // R5: pending flag is sticky until a control write
        p_ip_sticky_r5: assert property (@(posedge clk) disable iff (rst)
            (irq[n] && !(ctl_acc && bus_wr)) |=> irq[n]);

        // R7: writing 0 to the pending bit with no tick clears it
        p_ip_clear_r7: assert property (@(posedge clk) disable iff (rst)
            (ctl_acc && bus_wr && !bus_wdata[4] && !tick) |=> !irq[n]);

        // R3: an interrupt only appears after a tick
        p_rise_tick_r3: assert property (@(posedge clk) disable iff (rst)
            $rose(irq[n]) |-> $past(tick));

        // R8: load trigger and hardwired bits read zero
        p_ctl_zero_bits_r8: assert property (@(posedge clk) disable iff (rst)
            (ctl_acc && !bus_wr) |-> (bus_rdata[2] == 1'b0 && bus_rdata[31:6] == '0));
    end
endmodule

bind multi_timer multi_timer_chk #(.N_TMR(N_TMR), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/multi_timer_test.sv
module multi_timer_test;
    localparam int unsigned AW = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_be = 4'hF;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;

    multi_timer uut (
        .clk(clk), .rst(rst), .tick(tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_be(bus_be), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    bit    mon_go = 1'b0;
    bit    done = 1'b0;

    // monitor: pops expected items and compares away from the active edge
    always @(negedge clk) begin
        if (mon_go) begin
            item_t       it;
            logic [31:0] act;
            it  = q.pop_front();
            act = it.is_irq ? {28'b0, irq} : bus_rdata;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 4'hF;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag,
                      input logic [3:0] be = 4'hF);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = be;
        q.push_back('{1'b0, e, tag});
        mon_go = 1'b1;
        @(posedge clk); #1;
        bus_sel = 1'b0; mon_go = 1'b0; bus_be = 4'hF;
    endtask

    task automatic irq_chk(input logic [3:0] e, input string tag);
        @(posedge clk); #1;
        q.push_back('{1'b1, {28'b0, e}, tag});
        mon_go = 1'b1;
        @(posedge clk); #1;
        mon_go = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        @(posedge clk); #1;
        tick = 1'b1;
        repeat (n) @(posedge clk);
        #1;
        tick = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 / R11: reset image
        rd(7'h00, 32'h0, "R1 prescaler counter");
        rd(7'h04, 32'h0, "R1 prescaler reload");
        rd(7'h18, 32'h0, "R1 ch0 control");
        rd(7'h48, 32'h09, "R1 ch3 control armed");
        rd(7'h40, 32'hFFFF, "R1 ch3 counter");
        rd(7'h44, 32'hFFFF, "R1 ch3 reload R11");
        irq_chk(4'b0000, "R1 irq low");

        // R2/R3/R4/R5: watchdog at one pulse per tick, stops on underflow
        run_ticks(65535);
        rd(7'h40, 32'h0, "R3 ch3 reaches zero");
        irq_chk(4'b0000, "R5 no irq before underflow");
        run_ticks(1);
        irq_chk(4'b1000, "R5 ch3 irq on underflow");
        rd(7'h48, 32'h18, "R4 stop clears enable, sets pending");
        rd(7'h40, 32'h0, "R4 stopped counter stays zero");

        // R7: write 1 to pending keeps it, write 0 clears
        wr(7'h48, 32'h18);
        rd(7'h48, 32'h18, "R7 writing one keeps pending");
        wr(7'h48, 32'h08);
        rd(7'h48, 32'h08, "R7 writing zero clears pending");
        irq_chk(4'b0000, "R7 irq dropped");

        // R2/R6: prescaler of 3, load trigger
        wr(7'h04, 32'd3);
        wr(7'h00, 32'd3);
        wr(7'h14, 32'd4);
        wr(7'h18, 32'h0F);
        rd(7'h18, 32'h0B, "R6 load bit reads zero");
        rd(7'h10, 32'd4, "R6 load copies reload");
        run_ticks(3);
        rd(7'h00, 32'd3, "R2 prescaler reloaded");
        rd(7'h10, 32'd3, "R3 one decrement per pulse");
        run_ticks(2);
        rd(7'h00, 32'd1, "R2 prescaler mid period");
        rd(7'h10, 32'd3, "R3 no decrement without pulse");
        run_ticks(7);
        rd(7'h10, 32'd0, "R3 ch0 at zero");
        irq_chk(4'b0000, "R5 no early irq");
        run_ticks(3);
        rd(7'h10, 32'd4, "R4 restart reloads");
        irq_chk(4'b0001, "R5 ch0 irq");
        rd(7'h18, 32'h1B, "R4 restart keeps enable");

        // R5: interrupt enable clear
        wr(7'h18, 32'h03);
        irq_chk(4'b0000, "R7 cleared by control write");
        run_ticks(12);
        rd(7'h10, 32'd0, "R3 ch0 counted down");
        run_ticks(3);
        rd(7'h10, 32'd4, "R4 reload without interrupt");
        irq_chk(4'b0000, "R5 no pending when disabled");

        // R9: chained channel 1
        wr(7'h24, 32'd1);
        wr(7'h28, 32'h2F);
        rd(7'h28, 32'h2B, "R8 writable mask on ch1");
        run_ticks(14);
        rd(7'h20, 32'd1, "R9 chained ignores pulses");
        run_ticks(1);
        rd(7'h20, 32'd0, "R9 chained steps on underflow");
        run_ticks(15);
        rd(7'h20, 32'd1, "R9 chained reload");
        irq_chk(4'b0010, "R9 chained irq");

        // R10: partial accesses
        wr(7'h34, 32'h55, 4'h1);
        rd(7'h34, 32'h0, "R10 partial write ignored");
        rd(7'h44, 32'h0, "R10 partial read zero", 4'h1);
        rd(7'h44, 32'hFFFF, "R10 full read intact");

        // R8: hardwired bits
        wr(7'h38, 32'h50);
        rd(7'h38, 32'h0, "R8 bit6 and IP write ignored");
        wr(7'h38, 32'hFFFF_FFFF);
        rd(7'h38, 32'h2B, "R8 upper bits read zero");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule